// File: doc/BRIEF.md
# Absolute Loader Tape Parser

This block turns a byte stream from a paper-tape style reader into memory writes. Each accepted byte arrives with a one-cycle valid strobe. The parser walks through the framed blocks on the tape and deposits their data bytes into a 16-bit word memory through two byte-lane write enables. When it meets the closing block, it reports completion and an optional program start address.

A block opens with a byte of value 1. Next comes one don't-care byte, then a 16-bit byte count (low byte first) and a 16-bit load origin (low byte first). The count includes the six header bytes. After the header come count-6 data bytes and a closing checksum byte. The modulo-256 sum of every byte from the opening 1 through the checksum must be zero. A block whose count is exactly six ends the tape: it has no data and no checksum. Errors are sticky and leave the parser idle until a synchronous start pulse re-arms it. An end-of-stream strobe from the reader marks where the tape runs out.

Top module: `papertape_loader`

## Requirements
- R1: After reset the parser is idle. `done`, `start_valid`, `err_code` and `mem_we` are all zero, and accepted bytes cause no writes until `start` is pulsed. `start` clears `done`, `start_valid`, `start_addr` and `err_code` and arms the parser to look for a block.
- R2: While the parser looks for a block, every byte other than 1 is skipped and clears the running checksum. A byte of value 1 opens a block. The byte after it is discarded, whatever its value.
- R3: The count and the origin are each taken low byte first. A block with count N (N > 6) delivers N-6 data bytes to consecutive ascending byte addresses, starting at the origin.
- R4: A data byte at byte address A is written one cycle after it is accepted. The write goes to word `mem_addr` = A>>1, with `mem_wdata` carrying the byte in both halves. `mem_we` = 2'b01 when A is even (bits 7:0) and 2'b10 when A is odd (bits 15:8). At most one lane is enabled, so the other byte of the word is preserved.
- R5: At a block's checksum byte, if the low 8 bits of the sum of all bytes from the opening 1 through the checksum are zero, the parser goes back to looking for the next block. Otherwise `err_code` becomes 1.
- R6: A block with count exactly 6 sets `done`. If its origin is not 1, `start_valid` is set and `start_addr` = origin with bit 0 cleared. An origin of 1 leaves `start_valid` at 0.
- R7: A data byte whose byte address is at or above `MEM_BYTES` is not written, and `err_code` becomes 2.
- R8: `err_code` becomes 3 in two cases: `in_end` is strobed while armed but before the closing block, or a block's count is below 6.
- R9: A nonzero `err_code` stays unchanged, and further bytes cause no writes, until `start` is pulsed.
- R10: After `done`, further bytes and `in_end` cause no writes and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Synchronous clear and arm |
| in_valid | input | 1 | Byte strobe from reader |
| in_byte | input | 8 | Tape byte |
| in_end | input | 1 | Reader reports end of stream |
| mem_we | output | 2 | Byte-lane write enables {high, low} |
| mem_addr | output | $clog2(MEM_BYTES/2) | Word address |
| mem_wdata | output | 16 | Write data, byte copied to both lanes |
| done | output | 1 | Closing block seen |
| start_valid | output | 1 | Start address present |
| start_addr | output | 16 | Program start address, even |
| err_code | output | 2 | 0 none, 1 checksum, 2 non-existent memory, 3 format |

## Verification
The hardest case to reach from the ports is a data run that crosses the top of memory partway through a block. Lanes must keep being written up to the last legal byte, and the next byte must abort without a write. The bench builds a block whose origin sits three bytes below the limit and whose length is five, then compares the whole memory against its own model. A near-exhaustive sweep covers sixty blocks with every parity of origin and lengths one to five, with varied discarded bytes and stray leader bytes, so that lane selection and checksum clearing are exercised broadly.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_LEAD, S_SKIP, S_CLO, S_CHI, S_OLO, S_OHI, S_DATA, S_SUM, S_DONE
  } ldr_state_t;

  typedef enum logic [1:0] {
    E_NONE = 2'd0,
    E_CSUM = 2'd1,
    E_NXM  = 2'd2,
    E_FMT  = 2'd3
  } ldr_err_t;

  localparam logic [7:0]  BLK_MARK  = 8'd1;
  localparam logic [15:0] HDR_BYTES = 16'd6;
  localparam logic [15:0] NO_START  = 16'd1;
endpackage

// File: rtl/ldr_csum.sv
module ldr_csum (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       take,
  input  logic       in_lead,
  input  logic [7:0] in_byte,
  output logic       sum_zero
);
  import ldr_pkg::*;
  logic [7:0] sum;
  logic [7:0] sum_nxt;

  always_comb sum_nxt = sum + in_byte;
  always_comb sum_zero = (sum_nxt == 8'd0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sum <= 8'd0;
    end else if (take) begin
      if (in_lead) sum <= (in_byte == BLK_MARK) ? BLK_MARK : 8'd0;
      else         sum <= sum_nxt;
    end
  end
endmodule

// File: rtl/ldr_wr.sv
module ldr_wr #(
  parameter int ADDR_W = 16,
  parameter int WAW    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] org,
  input  logic [7:0]        data,
  output logic [1:0]        mem_we,
  output logic [WAW-1:0]    mem_addr,
  output logic [15:0]       mem_wdata
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) mem_we[g] <= 1'b0;
      else     mem_we[g] <= req && (org[0] == 1'(g));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (req) begin
      mem_addr  <= org[WAW:1];
      mem_wdata <= {data, data};
    end
  end

  AST_LANE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mem_we)); // R4
endmodule

// File: rtl/ldr_fsm.sv
module ldr_fsm #(
  parameter int MEM_BYTES = 1024,
  parameter int ADDR_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                in_valid,
  input  logic [7:0]          in_byte,
  input  logic                in_end,
  input  logic                sum_zero,
  output ldr_pkg::ldr_state_t state,
  output logic                busy,
  output logic                take,
  output logic                wr_req,
  output logic [ADDR_W-1:0]   wr_org,
  output logic                done,
  output logic                start_valid,
  output logic [ADDR_W-1:0]   start_addr,
  output ldr_pkg::ldr_err_t   err
);
  import ldr_pkg::*;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_BYTES);

  logic [15:0]       cnt;
  logic [ADDR_W-1:0] org;
  logic [ADDR_W-1:0] full_org;
  logic              in_range;

  always_comb busy     = (state != S_IDLE) && (state != S_DONE);
  always_comb take     = in_valid && busy && !start && !in_end;
  always_comb in_range = ({1'b0, org} < LIMIT);
  always_comb wr_req   = take && (state == S_DATA) && in_range;
  always_comb wr_org   = org;
  always_comb full_org = {in_byte, org[7:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; cnt <= '0; org <= '0;
      done <= 1'b0; start_valid <= 1'b0; start_addr <= '0; err <= E_NONE;
    end else if (start) begin
      state <= S_LEAD;
      done <= 1'b0; start_valid <= 1'b0; start_addr <= '0; err <= E_NONE;
    end else if (in_end && busy) begin
      err   <= E_FMT;
      state <= S_IDLE;
    end else if (take) begin
      case (state)
        S_LEAD: if (in_byte == BLK_MARK) state <= S_SKIP;
        S_SKIP: state <= S_CLO;
        S_CLO: begin cnt[7:0]  <= in_byte; state <= S_CHI; end
        S_CHI: begin cnt[15:8] <= in_byte; state <= S_OLO; end
        S_OLO: begin org[7:0]  <= in_byte; state <= S_OHI; end
        S_OHI: begin
          org <= full_org;
          if (cnt == HDR_BYTES) begin
            done        <= 1'b1;
            start_valid <= (full_org != NO_START);
            start_addr  <= {full_org[ADDR_W-1:1], 1'b0};
            state       <= S_DONE;
          end else if (cnt < HDR_BYTES) begin
            err   <= E_FMT;
            state <= S_IDLE;
          end else begin
            cnt   <= cnt - HDR_BYTES;
            state <= S_DATA;
          end
        end
        S_DATA: begin
          if (!in_range) begin
            err   <= E_NXM;
            state <= S_IDLE;
          end else begin
            org <= org + 1'b1;
            cnt <= cnt - 1'b1;
            if (cnt == 16'd1) state <= S_SUM;
          end
        end
        S_SUM: begin
          if (sum_zero) state <= S_LEAD;
          else begin
            err   <= E_CSUM;
            state <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    done |-> (err == E_NONE)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((err != E_NONE) && !start) |=> (err == $past(err))); // R9
  AST_IDLE_NOWR: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE || state == S_DONE) |-> !wr_req); // R1
endmodule

// File: rtl/papertape_loader.sv
module papertape_loader #(
  parameter int MEM_BYTES = 1024,
  parameter int ADDR_W    = 16,
  localparam int MEM_WORDS = MEM_BYTES / 2,
  localparam int WAW       = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              in_end,
  output logic [1:0]        mem_we,
  output logic [WAW-1:0]    mem_addr,
  output logic [15:0]       mem_wdata,
  output logic              done,
  output logic              start_valid,
  output logic [ADDR_W-1:0] start_addr,
  output logic [1:0]        err_code
);
  import ldr_pkg::*;

  ldr_state_t        state;
  ldr_err_t          err;
  logic              busy, take, wr_req, sum_zero;
  logic [ADDR_W-1:0] wr_org;

  ldr_fsm #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .in_byte(in_byte), .in_end(in_end), .sum_zero(sum_zero),
    .state(state), .busy(busy), .take(take), .wr_req(wr_req),
    .wr_org(wr_org), .done(done), .start_valid(start_valid),
    .start_addr(start_addr), .err(err)
  );

  ldr_csum u_csum (
    .clk(clk), .rst(rst), .clr(start), .take(take),
    .in_lead(state == S_LEAD), .in_byte(in_byte), .sum_zero(sum_zero)
  );

  ldr_wr #(.ADDR_W(ADDR_W), .WAW(WAW)) u_wr (
    .clk(clk), .rst(rst), .req(wr_req), .org(wr_org), .data(in_byte),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always_comb err_code = err;

  AST_START_EVEN: assert property (@(posedge clk) disable iff (rst)
    start_valid |-> !start_addr[0]); // R6
  AST_NO_WR_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> (mem_we == 2'b00)); // R9
endmodule

// File: tb/tb_papertape_loader.sv
module tb_papertape_loader;
  localparam int MEM_BYTES = 1024;
  localparam int NW = MEM_BYTES / 2;

  logic clk = 1'b0;
  logic rst = 1'b1, start = 1'b0, in_valid = 1'b0, in_end = 1'b0;
  logic [7:0] in_byte = 8'd0;
  logic [1:0] mem_we;
  logic [8:0] mem_addr;
  logic [15:0] mem_wdata, start_addr;
  logic done, start_valid;
  logic [1:0] err_code;

  always #2.5 clk = ~clk;

  papertape_loader #(.MEM_BYTES(MEM_BYTES)) dut (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .in_byte(in_byte), .in_end(in_end), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done),
    .start_valid(start_valid), .start_addr(start_addr), .err_code(err_code)
  );

  logic [15:0] mem [NW];
  logic [15:0] exp_mem [NW];
  int wr_count = 0;
  int checks = 0, failures = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (mem_we[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
    if (mem_we[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
    if (mem_we != 2'b00) wr_count <= wr_count + 1;
  end

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic cmp_mem(string req);
    int bad = 0, first = -1;
    for (int i = 0; i < NW; i++)
      if (mem[i] !== exp_mem[i]) begin bad++; if (first < 0) first = i; end
    checks++;
    if (bad != 0) begin
      failures++;
      $display("FAIL %s memory word %0d actual=%0h expected=%0h",
               req, first, mem[first], exp_mem[first]);
    end
  endtask

  function automatic logic [7:0] dbyte(int org, int k);
    return 8'(org * 7 + k * 53 + 11);
  endfunction

  task automatic push(logic [7:0] b, inout logic [7:0] sum);
    @(negedge clk); in_valid = 1'b1; in_byte = b;
    @(negedge clk); in_valid = 1'b0;
    sum = sum + b;
  endtask

  task automatic arm();
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic end_strobe();
    @(negedge clk); in_end = 1'b1; @(negedge clk); in_end = 1'b0;
  endtask

  task automatic settle(); repeat (3) @(negedge clk); endtask

  task automatic block(int org, int len, logic [7:0] ign, bit bad, bit upd);
    logic [7:0] s = 8'd0;
    int cnt = len + 6;
    push(8'd1, s); push(ign, s);
    push(8'(cnt), s); push(8'(cnt >> 8), s);
    push(8'(org), s); push(8'(org >> 8), s);
    for (int k = 0; k < len; k++) begin
      int a = org + k;
      logic [7:0] d = dbyte(org, k);
      push(d, s);
      if (upd && a < MEM_BYTES) begin
        if (a % 2 == 1) exp_mem[a / 2][15:8] = d;
        else            exp_mem[a / 2][7:0]  = d;
      end
    end
    begin
      logic [7:0] c = 8'(-s) ^ (bad ? 8'h01 : 8'h00);
      push(c, s);
    end
  endtask

  task automatic final_blk(int org);
    logic [7:0] s = 8'd0;
    push(8'd1, s); push(8'd0, s); push(8'd6, s); push(8'd0, s);
    push(8'(org), s); push(8'(org >> 8), s);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      mem[i] = 16'(i * 257) ^ 16'h5A3C;
      exp_mem[i] = 16'(i * 257) ^ 16'h5A3C;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int wc;
    logic [7:0] junk = 8'd0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", done, 0);
    chk("R1 start_valid", start_valid, 0);
    chk("R1 err", err_code, 0);
    chk("R1 we", mem_we, 0);
    block(4, 3, 8'h00, 0, 0);
    settle();
    chk("R1 no write before start", wr_count, 0);

    // R2 R3 R4 sweep over origin parity and length
    arm();
    push(8'd0, junk); push(8'd0, junk); push(8'd0, junk);
    for (int o = 0; o < 12; o++)
      for (int len = 1; len <= 5; len++) begin
        block(o * 21 + len, len, 8'(o * len * 29), 0, 1);
        if (len % 2 == 1) push(8'd0, junk);
        if (len == 4) push(8'h37, junk); // R2 stray leader byte clears sum
      end
    block(600, 300, 8'd1, 0, 1); // R3 count high byte nonzero
    final_blk(16'h0123);
    settle();
    cmp_mem("R3 R4 sweep memory");
    chk("R5 err after good blocks", err_code, 0);
    chk("R6 done", done, 1);
    chk("R6 start_valid", start_valid, 1);
    chk("R6 start_addr odd origin", start_addr, 16'h0122);

    // R10 ignored after done
    wc = wr_count;
    block(10, 2, 8'h00, 0, 0);
    end_strobe();
    settle();
    chk("R10 no write after done", wr_count, wc);
    chk("R10 no error after done", err_code, 0);
    chk("R10 done holds", done, 1);

    // R6 origin 1 means no start address
    arm();
    chk("R1 start clears done", done, 0);
    push(8'h55, junk);
    block(100, 3, 8'hFF, 0, 1);
    final_blk(1);
    settle();
    chk("R6 origin1 done", done, 1);
    chk("R6 origin1 start_valid", start_valid, 0);
    chk("R2 garbage leader no error", err_code, 0);
    cmp_mem("R4 after origin1 block");

    arm();
    final_blk(16'h0456);
    settle();
    chk("R6 even origin start_addr", start_addr, 16'h0456);

    // R5 bad checksum, R9 sticky
    arm();
    block(200, 2, 8'h00, 1, 1);
    settle();
    chk("R5 checksum error", err_code, 1);
    chk("R5 no done", done, 0);
    wc = wr_count;
    block(300, 2, 8'h00, 0, 0);
    final_blk(16'h0200);
    settle();
    chk("R9 no write after error", wr_count, wc);
    chk("R9 error sticky", err_code, 1);
    chk("R9 no done after error", done, 0);
    arm();
    chk("R9 start clears error", err_code, 0);

    // R7 crossing memory top
    block(MEM_BYTES - 3, 5, 8'h00, 0, 1);
    settle();
    chk("R7 nxm error", err_code, 2);
    cmp_mem("R7 memory up to limit");

    // R8 premature end
    arm();
    block(50, 2, 8'h00, 0, 1);
    end_strobe();
    settle();
    chk("R8 premature end", err_code, 3);

    // R8 short count
    arm();
    push(8'd1, junk); push(8'd0, junk); push(8'd4, junk); push(8'd0, junk);
    push(8'd0, junk); push(8'd0, junk);
    settle();
    chk("R8 count below six", err_code, 3);
    cmp_mem("R8 memory final");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule